// File: doc/BRIEF.md
# Commutation Shadow Register Controller

This block keeps two copies of the per-channel output controls of a timer that drives complementary output pairs. Each channel has a main output enable, a complementary output enable and an output compare mode. A software write first lands in a pending copy. The active copy is what the output stage sees. When shadowing is turned on, the active copy of a channel that has a complementary output changes only on a commutation event. All channels then switch their output pattern on the same clock edge, which keeps a motor-drive phase change glitch-free.

A commutation event is always raised by a one-cycle software strobe. When the event-source select is set, a rising edge on the external trigger input also raises one. A small two-state machine follows the trigger level, with states TRIG_LOW and TRIG_HIGH. The transition from TRIG_LOW to TRIG_HIGH is taken when the trigger is seen high, and it is the only transition that reports an edge. The transition from TRIG_HIGH back to TRIG_LOW is taken when the trigger is seen low. In every other case the machine stays in its state.

Channels flagged as having no complementary output ignore both the shadow enable and the event-source select, and take writes directly. Dead-time insertion, the output stage and the bus interface belong to other blocks.

Top module: `commutation_shadow_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every active output (act_oe, act_ne, act_mode) is zero, and every pending field is zero.
- R2: With shadow_en at 0, a write with wr_valid at 1 to channel wr_chan appears on that channel's active outputs in the cycle after the write edge.
- R3: With shadow_en at 1 and has_comp[c] at 1, a write to channel c leaves c's active outputs unchanged until a commutation event, which loads the pending values.
- R4: With trig_src_sel at 0, a rising edge on trig_in causes no commutation event; only sw_commute does.
- R5: With trig_src_sel at 1, trig_in high in a cycle after a cycle where it was low is a commutation event (trig_in is taken as low before the first cycle after reset); trig_in held high raises no further event.
- R6: A channel with has_comp[c] at 0 takes writes directly on the next cycle, whatever the values of shadow_en and trig_src_sel.
- R7: A write in the same cycle as a commutation event becomes pending. The event loads the value that was pending before the write, and the new value is applied at the next event.
- R8: A software strobe and a trigger edge in the same cycle act as one event; the pending values stay held after an event, so a later event with no write between leaves the active outputs unchanged.
- R9: Channel c occupies act_mode bits [c*MODE_W +: MODE_W]; a write to channel c never changes any other channel's active or pending fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shadow_en | input | 1 | 1: channels with a complementary output shadow their fields |
| trig_src_sel | input | 1 | 1: trigger rising edge also raises a commutation event |
| sw_commute | input | 1 | One-cycle software commutation strobe |
| trig_in | input | 1 | External trigger level |
| has_comp | input | NUM_CH | Per-channel flag: channel has a complementary output |
| wr_valid | input | 1 | Field write strobe |
| wr_chan | input | $clog2(NUM_CH) | Channel index of the write |
| wr_oe | input | 1 | Written main output enable |
| wr_ne | input | 1 | Written complementary output enable |
| wr_mode | input | MODE_W | Written output compare mode |
| act_oe | output | NUM_CH | Active main output enables |
| act_ne | output | NUM_CH | Active complementary output enables |
| act_mode | output | NUM_CH*MODE_W | Active compare modes, packed by channel |

## Verification
The assertions assume that shadow_en, trig_src_sel and has_comp are quasi-static, which means they change only in cycles with no write and no strobe. They also assume that wr_chan always names an existing channel. The stimulus changes configuration only between write and strobe phases, and it draws channel indices from the configured range. The bench sweeps every has_comp pattern of a four-channel instance under all four combinations of shadow_en and trig_src_sel. Within each sweep it walks write, trigger-edge, held-trigger and strobe phases. Expected outputs come from a per-requirement reference computed in the bench.

// File: rtl/cmsh_pkg.sv
package cmsh_pkg;

    // Trigger tracker states
    typedef enum logic {
        TRIG_LOW  = 1'b0,
        TRIG_HIGH = 1'b1
    } trig_state_e;

    // Commutation event source select encoding
    typedef enum logic {
        SRC_SW_ONLY    = 1'b0,
        SRC_SW_OR_TRIG = 1'b1
    } evt_src_e;

endpackage

// File: rtl/cmsh_trig_edge.sv
module cmsh_trig_edge
    import cmsh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic trig_rise
);

    trig_state_e state_q;
    trig_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRIG_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and edge output
    always_comb begin
        state_d   = state_q;
        trig_rise = 1'b0;
        unique case (state_q)
            TRIG_LOW: begin
                if (trig_in) begin
                    state_d   = TRIG_HIGH;
                    trig_rise = 1'b1;
                end
            end
            TRIG_HIGH: begin
                if (!trig_in) begin
                    state_d = TRIG_LOW;
                end
            end
            default: begin
                state_d = TRIG_LOW;
            end
        endcase
    end

    // R5
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_rise |=> !trig_rise);

    // R5
    held_high_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_in && $past(trig_in) && $past(rst_n)) |-> !trig_rise);

endmodule

// File: rtl/cmsh_event_sel.sv
module cmsh_event_sel
    import cmsh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_commute,
    input  logic trig_rise,
    input  logic trig_src_sel,
    output logic commit
);

    evt_src_e src;

    always_comb begin
        src = evt_src_e'(trig_src_sel);
        unique case (src)
            SRC_SW_ONLY:    commit = sw_commute;
            SRC_SW_OR_TRIG: commit = sw_commute | trig_rise;
            default:        commit = sw_commute;
        endcase
    end

    // R4
    trig_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_src_sel && !sw_commute) |-> !commit);

    // R8
    strobe_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_commute |-> commit);

endmodule

// File: rtl/cmsh_chan_slot.sv
module cmsh_chan_slot #(
    parameter int MODE_W  = 3,
    localparam int FIELD_W = MODE_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shadow_en,
    input  logic              has_comp,
    input  logic              commit,
    input  logic              wr_hit,
    input  logic              wr_oe,
    input  logic              wr_ne,
    input  logic [MODE_W-1:0] wr_mode,
    output logic              act_oe,
    output logic              act_ne,
    output logic [MODE_W-1:0] act_mode
);

    // Field layout inside a slot: {oe, ne, mode}
    logic [FIELD_W-1:0] wdata;
    logic [FIELD_W-1:0] pend_q;
    logic [FIELD_W-1:0] act_q;
    logic [FIELD_W-1:0] act_d;
    logic               shadowed;

    assign wdata    = {wr_oe, wr_ne, wr_mode};
    assign shadowed = shadow_en & has_comp;

    // Pending copy always captures writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (wr_hit) begin
            pend_q <= wdata;
        end
    end

    // Active copy: direct write when unshadowed, pending load on commit
    always_comb begin
        act_d = act_q;
        if (shadowed) begin
            if (commit) begin
                act_d = pend_q;
            end
        end else if (wr_hit) begin
            act_d = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '0;
        end else begin
            act_q <= act_d;
        end
    end

    assign act_oe   = act_q[FIELD_W-1];
    assign act_ne   = act_q[FIELD_W-2];
    assign act_mode = act_q[MODE_W-1:0];

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (act_q == '0 && pend_q == '0));

    // R2
    direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shadowed && wr_hit) |=> ({act_oe, act_ne, act_mode} == $past(wdata)));

    // R3
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shadowed && !commit) |=> $stable({act_oe, act_ne, act_mode}));

    // R7
    commit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shadowed && commit) |=> ({act_oe, act_ne, act_mode} == $past(pend_q)));

    // R9
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(pend_q));

endmodule

// File: rtl/commutation_shadow_ctrl.sv
module commutation_shadow_ctrl #(
    parameter int NUM_CH = 4,
    parameter int MODE_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      shadow_en,
    input  logic                      trig_src_sel,
    input  logic                      sw_commute,
    input  logic                      trig_in,
    input  logic [NUM_CH-1:0]         has_comp,
    input  logic                      wr_valid,
    input  logic [$clog2(NUM_CH)-1:0] wr_chan,
    input  logic                      wr_oe,
    input  logic                      wr_ne,
    input  logic [MODE_W-1:0]         wr_mode,
    output logic [NUM_CH-1:0]         act_oe,
    output logic [NUM_CH-1:0]         act_ne,
    output logic [NUM_CH*MODE_W-1:0]  act_mode
);

    localparam int CH_IDX_W = $clog2(NUM_CH);

    logic trig_rise;
    logic commit;

    cmsh_trig_edge u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_in   (trig_in),
        .trig_rise (trig_rise)
    );

    cmsh_event_sel u_evt (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_commute   (sw_commute),
        .trig_rise    (trig_rise),
        .trig_src_sel (trig_src_sel),
        .commit       (commit)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic wr_hit;
        assign wr_hit = wr_valid && (wr_chan == CH_IDX_W'(c));

        cmsh_chan_slot #(.MODE_W(MODE_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .shadow_en (shadow_en),
            .has_comp  (has_comp[c]),
            .commit    (commit),
            .wr_hit    (wr_hit),
            .wr_oe     (wr_oe),
            .wr_ne     (wr_ne),
            .wr_mode   (wr_mode),
            .act_oe    (act_oe[c]),
            .act_ne    (act_ne[c]),
            .act_mode  (act_mode[c*MODE_W +: MODE_W])
        );

        // R6
        no_comp_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!has_comp[c] && wr_hit) |=>
            ({act_oe[c], act_ne[c], act_mode[c*MODE_W +: MODE_W]} ==
             $past({wr_oe, wr_ne, wr_mode})));
    end

    // R9
    wr_chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (int'(wr_chan) < NUM_CH));

endmodule

// File: tb/commutation_shadow_ctrl_tb.sv
module commutation_shadow_ctrl_tb_top;

    localparam int NCH = 4;
    localparam int MW  = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           shadow_en = 1'b0, trig_src_sel = 1'b0, sw_commute = 1'b0, trig_in = 1'b0;
    logic [NCH-1:0] has_comp = '1;
    logic           wr_valid = 1'b0;
    logic [1:0]     wr_chan = '0;
    logic           wr_oe = 1'b0, wr_ne = 1'b0;
    logic [MW-1:0]  wr_mode = '0;
    logic [NCH-1:0]    act_oe, act_ne;
    logic [NCH*MW-1:0] act_mode;

    int checks = 0;
    int errors = 0;

    // Reference state
    logic [MW+1:0] m_act  [NCH];
    logic [MW+1:0] m_pend [NCH];
    logic          m_trig_prev;

    always #2 clk = ~clk;

    commutation_shadow_ctrl #(.NUM_CH(NCH), .MODE_W(MW)) dut_i (
        .clk(clk), .rst_n(rst_n), .shadow_en(shadow_en), .trig_src_sel(trig_src_sel),
        .sw_commute(sw_commute), .trig_in(trig_in), .has_comp(has_comp),
        .wr_valid(wr_valid), .wr_chan(wr_chan), .wr_oe(wr_oe), .wr_ne(wr_ne),
        .wr_mode(wr_mode), .act_oe(act_oe), .act_ne(act_ne), .act_mode(act_mode)
    );

    function automatic logic [NCH*(MW+2)-1:0] expect_vec();
        logic [NCH*(MW+2)-1:0] v;
        for (int c = 0; c < NCH; c++) v[c*(MW+2) +: MW+2] = m_act[c];
        return v;
    endfunction

    function automatic logic [NCH*(MW+2)-1:0] actual_vec();
        logic [NCH*(MW+2)-1:0] v;
        for (int c = 0; c < NCH; c++)
            v[c*(MW+2) +: MW+2] = {act_oe[c], act_ne[c], act_mode[c*MW +: MW]};
        return v;
    endfunction

    task automatic check_all(input string tag);
        checks++;
        if (actual_vec() !== expect_vec()) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, actual_vec(), expect_vec());
        end
    endtask

    // Called at a falling edge; drives one cycle and returns at the next falling edge
    task automatic step(input logic wv, input int ch, input logic [MW+1:0] d,
                        input logic sw, input logic tr);
        logic edge_seen, commit;
        wr_valid = wv; wr_chan = ch[1:0];
        {wr_oe, wr_ne, wr_mode} = d;
        sw_commute = sw; trig_in = tr;
        edge_seen = tr && !m_trig_prev;
        commit = sw || (trig_src_sel && edge_seen);
        for (int c = 0; c < NCH; c++) begin
            logic shad;
            shad = shadow_en && has_comp[c];
            if (shad && commit) m_act[c] = m_pend[c];
            if (wv && ch == c) begin
                m_pend[c] = d;
                if (!shad) m_act[c] = d;
            end
        end
        m_trig_prev = tr;
        @(negedge clk);
    endtask

    task automatic idle();
        step(1'b0, 0, '0, 1'b0, trig_in);
    endtask

    function automatic logic [MW+1:0] pat(input int k, input int c);
        return 5'((k * 7 + c * 3 + 1) % 32);
    endfunction

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin m_act[c] = '0; m_pend[c] = '0; end
        m_trig_prev = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after reset");

        // R2: unshadowed writes are direct
        shadow_en = 0; has_comp = '1;
        step(1'b1, 0, 5'b10101, 1'b0, 1'b0);
        check_all("R2 direct write");
        step(1'b1, 3, 5'b01110, 1'b0, 1'b0);
        check_all("R2/R9 direct write ch3");

        // R3: shadowed write held until strobe
        shadow_en = 1; trig_src_sel = 0;
        step(1'b1, 1, 5'b11011, 1'b0, 1'b0);
        check_all("R3 held pending");
        step(1'b0, 0, '0, 1'b1, 1'b0);
        check_all("R3 strobe commit");

        // R4: trigger ignored with select 0
        step(1'b1, 2, 5'b10011, 1'b0, 1'b0);
        step(1'b0, 0, '0, 1'b0, 1'b1);
        check_all("R4 trigger ignored");
        step(1'b0, 0, '0, 1'b0, 1'b0);

        // R5: trigger edge commits with select 1, held high does not
        trig_src_sel = 1;
        step(1'b0, 0, '0, 1'b0, 1'b1);
        check_all("R5 edge commit");
        step(1'b1, 2, 5'b01001, 1'b0, 1'b1);
        step(1'b0, 0, '0, 1'b0, 1'b1);
        check_all("R5 held high no commit");
        step(1'b0, 0, '0, 1'b0, 1'b0);

        // R6: channel without complementary output is direct
        has_comp = 4'b1011;
        step(1'b1, 2, 5'b11100, 1'b0, 1'b0);
        check_all("R6 no-comp direct");
        has_comp = '1;

        // R7: write coincident with commit
        trig_src_sel = 0;
        step(1'b1, 0, 5'b00111, 1'b0, 1'b0);
        step(1'b1, 0, 5'b11000, 1'b1, 1'b0);
        check_all("R7 old pending applied");
        step(1'b0, 0, '0, 1'b1, 1'b0);
        check_all("R7 new value next event");

        // R8: joint strobe and edge, then repeat event
        trig_src_sel = 1;
        step(1'b1, 3, 5'b10110, 1'b0, 1'b0);
        step(1'b0, 0, '0, 1'b1, 1'b1);
        check_all("R8 joint event");
        step(1'b0, 0, '0, 1'b1, 1'b0);
        check_all("R8 repeat event unchanged");

        // Sweep over configurations and channel flags
        for (int se = 0; se < 2; se++) begin
            for (int sel = 0; sel < 2; sel++) begin
                for (int hc = 0; hc < 16; hc++) begin
                    shadow_en = se[0]; trig_src_sel = sel[0]; has_comp = hc[3:0];
                    idle();
                    for (int c = 0; c < NCH; c++) begin
                        step(1'b1, c, pat(hc + se * 16 + sel * 32, c), 1'b0, 1'b0);
                        check_all("R2/R3/R6/R9 sweep write");
                    end
                    step(1'b0, 0, '0, 1'b0, 1'b1);
                    check_all("R4/R5 sweep trigger edge");
                    step(1'b1, hc % NCH, pat(hc, 9), 1'b0, 1'b1);
                    check_all("R5 sweep held trigger");
                    step(1'b0, 0, '0, 1'b1, 1'b0);
                    check_all("R3/R8 sweep strobe");
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule